// File: doc/BRIEF.md
# Alternating Read/Write Port Arbiter

This block sits in front of a small synchronous storage array that has a read port and a write port, each with its own select. On every rising clock edge the block starts at most one transaction. When only one port asks, that port gets the cycle. When both ask, the choice depends on what started in the previous cycle: after a read the write wins, and after a write or an idle cycle the read wins. If both selects are held, the started operations therefore alternate, with a read first.

A granted write is held in a one-entry buffer for a cycle and then committed to the array. A read that starts in the cycle right after a write to the same address takes its data from that buffer instead of the stale array word. Read data comes back one cycle after the read starts, together with a one-cycle valid strobe. A request that loses arbitration is not stored. Its requester sees the acknowledge stay low and must keep its select asserted.

Top module: `alt_rw_arbiter`

## Requirements
- R1: `rd_ack` and `wr_ack` are never high in the same cycle. A high acknowledge means that operation starts at the next rising edge.
- R2: If both selects are high and the previous cycle started nothing, the read is granted.
- R3: If both selects are high and the previous cycle started a read, the write is granted.
- R4: If both selects are high and the previous cycle started a write, the read is granted.
- R5: If both selects are held high starting from an idle cycle, the grants follow read, write, read, write, and so on.
- R6: A select that is high while the other select is low is always granted. The state of one port's select never stops a lone request on the other port.
- R7: `rd_valid` is high in exactly the cycle after a read grant, and `rd_data` then holds the word at the granted address.
- R8: A read granted in the cycle right after a write grant to the same address returns the newly written data.
- R9: A granted write is committed to the array even if its select drops in the following cycle.
- R10: A rejected request is not queued. If its select is low in the next cycle, nothing starts for that port.
- R11: Reset makes the previous operation idle, drives `rd_valid` low, and forces both acknowledges low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rd_sel | input | 1 | Read port select |
| rd_addr | input | ADDR_W | Read address |
| rd_ack | output | 1 | Read starts at the next rising edge |
| rd_data | output | DATA_W | Read data, one cycle after grant |
| rd_valid | output | 1 | Read data valid strobe |
| wr_sel | input | 1 | Write port select |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| wr_ack | output | 1 | Write starts at the next rising edge |

## Verification
The assertions assume the following about the inputs:
- Selects, addresses and write data are stable around each rising edge.
- Reset is asserted from time zero.
- The forwarding check compares against write data captured through the acknowledge handshake, so a write is only treated as started when `wr_ack` was high.

The stimulus changes inputs only on falling edges. It starts by writing every address so that no read returns an uninitialised word. The random phase often reuses the last write address so that forwarding cases occur, and directed sequences cover held dual selects, withdrawn requests and dropped selects after a write.

// File: rtl/arb_pkg.sv
package arb_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;
endpackage

// File: rtl/arb_grant.sv
module arb_grant
   import arb_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic rd_sel,
   input  logic wr_sel,
   output logic rd_go,
   output logic wr_go
);
   op_e last_q;

   // Priority follows the previous started operation when both ports ask
   always_comb begin
      rd_go = 1'b0;
      wr_go = 1'b0;
      if (!rst) begin
         if (rd_sel && wr_sel) begin
            if (last_q == OP_READ) wr_go = 1'b1;
            else                   rd_go = 1'b1;
         end else begin
            rd_go = rd_sel;
            wr_go = wr_sel;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst)        last_q <= OP_IDLE;
      else if (rd_go) last_q <= OP_READ;
      else if (wr_go) last_q <= OP_WRITE;
      else            last_q <= OP_IDLE;
   end
endmodule

// File: rtl/arb_store.sv
module arb_store #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/arb_fwd.sv
module arb_fwd #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16,
   parameter bit FWD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_go,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_go,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] arr_rdata,
   output logic              cm_en,
   output logic [ADDR_W-1:0] cm_addr,
   output logic [DATA_W-1:0] cm_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);
   logic              pend_q;
   logic [ADDR_W-1:0] pend_addr_q;
   logic [DATA_W-1:0] pend_data_q;
   logic [DATA_W-1:0] rd_pick;

   // One-entry write buffer: a started write always commits next edge
   always_ff @(posedge clk) begin
      if (rst) pend_q <= 1'b0;
      else     pend_q <= wr_go;
      if (wr_go) begin
         pend_addr_q <= wr_addr;
         pend_data_q <= wr_data;
      end
   end

   assign cm_en   = pend_q;
   assign cm_addr = pend_addr_q;
   assign cm_data = pend_data_q;

   generate
      if (FWD_EN) begin : g_fwd
         assign rd_pick = (pend_q && pend_addr_q == rd_addr) ? pend_data_q : arr_rdata;
      end else begin : g_nofwd
         assign rd_pick = arr_rdata;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) rd_valid <= 1'b0;
      else     rd_valid <= rd_go;
      if (rd_go) rd_data <= rd_pick;
   end
endmodule

// File: rtl/alt_rw_arbiter.sv
module alt_rw_arbiter #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_sel,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_ack,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   input  logic              wr_sel,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ack
);
   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("alt_rw_arbiter: ADDR_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("alt_rw_arbiter: DATA_W must be positive");
      end
   endgenerate

   logic              cm_en;
   logic [ADDR_W-1:0] cm_addr;
   logic [DATA_W-1:0] cm_data;
   logic [DATA_W-1:0] arr_rdata;

   arb_grant u_grant (
      .clk    (clk),
      .rst    (rst),
      .rd_sel (rd_sel),
      .wr_sel (wr_sel),
      .rd_go  (rd_ack),
      .wr_go  (wr_ack)
   );

   arb_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk   (clk),
      .we    (cm_en),
      .waddr (cm_addr),
      .wdata (cm_data),
      .raddr (rd_addr),
      .rdata (arr_rdata)
   );

   arb_fwd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FWD_EN(1'b1)) u_fwd (
      .clk       (clk),
      .rst       (rst),
      .wr_go     (wr_ack),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_go     (rd_ack),
      .rd_addr   (rd_addr),
      .arr_rdata (arr_rdata),
      .cm_en     (cm_en),
      .cm_addr   (cm_addr),
      .cm_data   (cm_data),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid)
   );
endmodule

// File: rtl/alt_rw_arbiter_chk.sv
module alt_rw_arbiter_chk #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              rd_sel,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              rd_ack,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_valid,
   input logic              wr_sel,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              wr_ack
);
   logic any_prev_q;
   always_ff @(posedge clk) begin
      if (rst) any_prev_q <= 1'b0;
      else     any_prev_q <= rd_ack | wr_ack;
   end

   // R1
   one_start_chk: assert property (@(posedge clk) disable iff (rst)
      !(rd_ack && wr_ack));
   // R2
   idle_read_first_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_sel && wr_sel && !any_prev_q) |-> rd_ack);
   // R3
   after_read_write_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_sel && wr_sel && $past(rd_ack)) |-> wr_ack);
   // R4
   after_write_read_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_sel && wr_sel && $past(wr_ack)) |-> rd_ack);
   // R6
   lone_read_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_sel && !wr_sel) |-> rd_ack);
   // R6
   lone_write_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_sel && !rd_sel) |-> wr_ack);
   // R7
   valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
      rd_ack |=> rd_valid);
   // R7
   valid_only_chk: assert property (@(posedge clk) disable iff (rst)
      !rd_ack |=> !rd_valid);
   // R8
   forward_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_ack && $past(wr_ack) && rd_addr == $past(wr_addr)) |=> rd_data == $past(wr_data, 2));
   // R10
   no_queue_chk: assert property (@(posedge clk) disable iff (rst)
      (!rd_sel |-> !rd_ack) and (!wr_sel |-> !wr_ack));
   // R11
   reset_valid_chk: assert property (@(posedge clk)
      rst |=> !rd_valid);
endmodule

bind alt_rw_arbiter alt_rw_arbiter_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/alt_rw_arbiter_tb.sv
`timescale 1ns/1ps
module alt_rw_arbiter_tb;
   localparam int AW = 6;
   localparam int DW = 16;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          rd_sel = 1'b0, wr_sel = 1'b0;
   logic [AW-1:0] rd_addr = '0, wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          rd_ack, wr_ack, rd_valid;
   logic [DW-1:0] rd_data;

   int checks = 0;
   int errors = 0;

   logic [DW-1:0] model [DEPTH];
   int            last_op = 0;   // 0 idle, 1 read, 2 write
   bit            pend_rd = 1'b0;
   bit            pend_fwd = 1'b0;
   logic [DW-1:0] pend_exp = '0;
   logic [AW-1:0] last_wa = '0;

   always #4 clk = ~clk;

   alt_rw_arbiter #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst(rst),
      .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_ack(rd_ack),
      .rd_data(rd_data), .rd_valid(rd_valid),
      .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int exp_grant(input bit rs, input bit ws, input int prev);
      if (rs && ws) return (prev == 1) ? 2 : 1;
      if (rs) return 1;
      if (ws) return 2;
      return 0;
   endfunction

   // one cycle: drive at falling edge, check acks, model the rising edge
   task automatic step(input bit rs, input logic [AW-1:0] ra, input bit ws,
                       input logic [AW-1:0] wa, input logic [DW-1:0] wd, output int g);
      @(negedge clk);
      check(rd_valid == pend_rd, "R7 valid", rd_valid, pend_rd);
      if (pend_rd)
         check(rd_data == pend_exp, pend_fwd ? "R8 forward" : "R7 data", rd_data, pend_exp);
      rd_sel = rs; rd_addr = ra; wr_sel = ws; wr_addr = wa; wr_data = wd;
      #1;
      g = exp_grant(rs, ws, last_op);
      check(!(rd_ack && wr_ack), "R1 single", {rd_ack, wr_ack}, 0);
      if (rs && ws)
         check(rd_ack == (g == 1) && wr_ack == (g == 2),
               last_op == 1 ? "R3 after read" : (last_op == 2 ? "R4 after write" : "R2 idle"),
               {rd_ack, wr_ack}, {g == 1, g == 2});
      else
         check(rd_ack == (g == 1) && wr_ack == (g == 2), "R6 R10 lone",
               {rd_ack, wr_ack}, {g == 1, g == 2});
      @(posedge clk);
      pend_rd  = (g == 1);
      pend_fwd = (g == 1) && (last_op == 2) && (ra == last_wa);
      if (g == 1) pend_exp = model[ra];
      if (g == 2) begin model[wa] = wd; last_wa = wa; end
      last_op = g;
   endtask

   initial begin
      #(8 * 200000);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int g;
      int seq [6];
      void'($urandom(32'h5eed));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R11: reset state
      check(rd_valid == 1'b0, "R11 valid", rd_valid, 0);
      rd_sel = 1; wr_sel = 1; #1;
      check(!rd_ack && !wr_ack, "R11 acks", {rd_ack, wr_ack}, 0);
      rd_sel = 0; wr_sel = 0;
      rst = 1'b0;
      // fill array with lone writes
      for (int a = 0; a < DEPTH; a++) step(0, '0, 1, AW'(a), DW'(a * 37 + 5), g);
      step(0, '0, 0, '0, '0, g);
      // R5: held dual selects from idle
      for (int i = 0; i < 6; i++) begin
         step(1, AW'(i), 1, AW'(i + 8), DW'(16'hA000 + i), g);
         seq[i] = g;
      end
      for (int i = 0; i < 6; i++)
         check(seq[i] == ((i % 2 == 0) ? 1 : 2), "R5 alternation", seq[i], (i % 2 == 0) ? 1 : 2);
      step(0, '0, 0, '0, '0, g);
      // R8: write then read same address
      step(0, '0, 1, 6'd20, 16'hBEEF, g);
      step(1, 6'd20, 0, '0, '0, g);
      // R9: write granted, select then dropped, read later
      step(0, '0, 1, 6'd21, 16'hC0DE, g);
      step(0, '0, 0, '0, '0, g);
      step(0, '0, 0, '0, '0, g);
      step(1, 6'd21, 0, '0, '0, g);
      step(0, '0, 0, '0, '0, g);
      check(model[21] == 16'hC0DE && rd_data == 16'hC0DE, "R9 commit", rd_data, 16'hC0DE);
      // R10: read wins, then dual, write wins; drop read select -> no read
      step(1, 6'd1, 0, '0, '0, g);
      step(1, 6'd2, 1, 6'd3, 16'h1111, g);
      check(g == 2, "R10 loser", g, 2);
      step(0, '0, 0, '0, '0, g);
      check(g == 0, "R10 no queue", g, 0);
      step(0, '0, 0, '0, '0, g);
      // random phase
      for (int n = 0; n < 3000; n++) begin
         bit rs, ws;
         logic [AW-1:0] ra, wa;
         rs = ($urandom % 3) != 0;
         ws = ($urandom % 3) != 0;
         ra = ($urandom % 2) ? last_wa : AW'($urandom);
         wa = ($urandom % 4 == 0) ? last_wa : AW'($urandom % 16);
         step(rs, ra, ws, wa, DW'($urandom), g);
      end
      step(0, '0, 0, '0, '0, g);
      step(0, '0, 0, '0, '0, g);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule